// File: doc/BRIEF.md
# SPI Hold Pause Gate

This block sits between the raw serial pins of an SPI slave and the slave's shift and decode core. It brings the chip select, serial clock, serial data and pause inputs into the system clock domain. From the synchronized serial clock it produces one-cycle rising-edge and falling-edge strobes for the core. When the pause input is driven low while the device is selected, the block stops passing those strobes. The core's shift position is therefore frozen, and the transfer continues from the same bit once the pause is lifted.

The pause starts and ends only while the serial clock is low, so the core never sees half of a clock pulse. If the pause is requested while the clock is high, it begins at the next falling edge, and that falling edge still reaches the core. If the pause is lifted while the clock is high, the core stays paused until the clock returns low. The output-enable for the serial data line drops as soon as the synchronized pause input is low, without waiting for the deferred pause to begin. The core can switch the whole pause function off with a status bit. Deselecting the device always clears any pause.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, `paused` is 0, `so_oe` is 0 and no strobe is issued.
- R2: While selected and not paused, every rising edge of `sck` gives exactly one `sck_rise_stb` pulse, and every falling edge gives exactly one `sck_fall_stb` pulse. At each rise strobe, `si_bit` carries the `si` level present at that rising edge, so the bits of a byte sent MSB first can be shifted in intact.
- R3: While `paused` is 1, no rise or fall strobe is issued, whatever `sck` and `si` do.
- R4: If `hold_n` goes low while `sck` is low (selected, `hold_dis` = 0), `paused` becomes 1 before the next rising edge of `sck`.
- R5: If `hold_n` goes low while `sck` is high, `paused` stays 0 until `sck` falls. The fall strobe for that edge is still issued, and `paused` becomes 1 after it.
- R6: Whenever `hold_n` is low (selected, `hold_dis` = 0), `so_oe` is 0, including the interval before a deferred pause begins.
- R7: The pause ends only while `sck` is low. If `hold_n` rises while `sck` is high, `paused` stays 1 until `sck` is low, and the falling edge of that high phase gives no strobe. The transfer then continues from the bit where it stopped.
- R8: When `cs_n` goes high, `paused` returns to 0, so every new selection starts unpaused.
- R9: With `hold_dis` = 1, `hold_n` has no effect: `paused` stays 0, strobes continue, and `so_oe` follows `core_so_oe`.
- R10: `so_oe` equals `core_so_oe` while selected and not paused, and is 0 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Raw chip select, low = selected |
| sck | input | 1 | Raw serial clock |
| si | input | 1 | Raw serial data in |
| hold_n | input | 1 | Raw pause request, low = pause |
| hold_dis | input | 1 | Core status bit, 1 = pause function off |
| core_so_oe | input | 1 | Core's wish to drive the serial output |
| sck_rise_stb | output | 1 | Gated rising-edge strobe to the core |
| sck_fall_stb | output | 1 | Gated falling-edge strobe to the core |
| si_bit | output | 1 | Synchronized serial data, valid at a rise strobe |
| so_oe | output | 1 | Final serial-output enable |
| paused | output | 1 | 1 while the pause is in force |

## Verification
The assertions check the following on every cycle: strobes stay masked while paused, the output enable stays off while paused, a pause requested with the clock low takes effect at once, a pause requested with the clock high stays off while the clock is still high, the pause ends only from a low clock, deselection clears the pause, and the disable bit keeps the block unpaused. Only the bench scenarios can show the sequence-level results. These are: a byte is reassembled intact across a pause, the falling edge of a deferred entry is delivered, the falling edge of a deferred exit is swallowed, and the output enable drops before the deferred pause begins.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    HG_RUN    = 2'd0,
    HG_ARMED  = 2'd1,
    HG_PAUSED = 2'd2,
    HG_RESUME = 2'd3
  } hg_state_t;

  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_SI   = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned PIN_CS   = 3;
  localparam int unsigned PIN_W    = 4;
endpackage

// File: rtl/hg_sync.sv
module hg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hg_edge.sv
module hg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/hg_fsm.sv
module hg_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic hold_req,
  input  logic sck_lvl,
  output logic pass,
  output logic paused
);
  hg_state_t st, nxt;
  logic      st_en;

  always_comb begin
    nxt = st;
    if (!sel) begin
      nxt = HG_RUN;
    end else begin
      unique case (st)
        HG_RUN:    if (hold_req) nxt = sck_lvl ? HG_ARMED : HG_PAUSED;
        HG_ARMED:  if (!hold_req) nxt = HG_RUN;
                   else if (!sck_lvl) nxt = HG_PAUSED;
        HG_PAUSED: if (!hold_req) nxt = sck_lvl ? HG_RESUME : HG_RUN;
        HG_RESUME: if (hold_req) nxt = HG_PAUSED;
                   else if (!sck_lvl) nxt = HG_RUN;
        default:   nxt = HG_RUN;
      endcase
    end
  end

  assign st_en = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= HG_RUN;
    else if (st_en) st <= nxt;
  end

  assign pass   = (st == HG_RUN) || (st == HG_ARMED);
  assign paused = (st == HG_PAUSED) || (st == HG_RESUME);

  // R4: request seen with clock low takes effect on the next cycle
  p_enter_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HG_RUN && hold_req && !sck_lvl) |=> paused);

  // R5: request seen with clock high does not pause while clock stays high
  p_defer_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused && hold_req && sck_lvl) |=> !paused);

  // R7: a selected pause only ends from a low clock
  p_exit_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && $past(sel)) |-> $past(!sck_lvl));

  // R8: deselection clears the pause
  p_desel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !paused);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic hold_dis,
  input  logic core_so_oe,
  output logic sck_rise_stb,
  output logic sck_fall_stb,
  output logic si_bit,
  output logic so_oe,
  output logic paused
);
  localparam logic [PIN_W-1:0] PIN_RST = (PIN_W'(1) << PIN_CS) | (PIN_W'(1) << PIN_HOLD);

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic sck_s, sel, hold_req, rise, fall, pass;

  assign pins_raw[PIN_SCK]  = sck;
  assign pins_raw[PIN_SI]   = si;
  assign pins_raw[PIN_HOLD] = hold_n;
  assign pins_raw[PIN_CS]   = cs_n;

  hg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign sck_s    = pins_s[PIN_SCK];
  assign si_bit   = pins_s[PIN_SI];
  assign sel      = ~pins_s[PIN_CS];
  assign hold_req = sel & ~pins_s[PIN_HOLD] & ~hold_dis;

  hg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(rise), .fall(fall)
  );

  hg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel(sel), .hold_req(hold_req),
    .sck_lvl(sck_s), .pass(pass), .paused(paused)
  );

  assign sck_rise_stb = rise & pass & sel;
  assign sck_fall_stb = fall & pass & sel;
  assign so_oe        = core_so_oe & sel & pass & ~hold_req;

  // R3: no strobe reaches the core while paused
  p_no_edge_paused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!sck_rise_stb && !sck_fall_stb));

  // R6: output is released during a pause
  p_hiz_paused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe);

  // R9: with the function disabled the gate never enters a pause
  p_dis_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_dis && !paused) |=> !paused);

  // R2: rise and fall strobes never coincide
  p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sck_rise_stb, sck_fall_stb}) <= 1);
endmodule

// File: tb/spi_hold_gate_test.sv
`timescale 1ns/1ps
module spi_hold_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic hold_dis = 1'b0, core_so_oe = 1'b0;
  logic sck_rise_stb, sck_fall_stb, si_bit, so_oe, paused;

  int checks = 0;
  int failures = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  logic [7:0] shreg = 8'h00;
  bit done = 1'b0;

  localparam int HALF = 8;

  always #2.5 clk = ~clk;

  spi_hold_gate uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .hold_dis(hold_dis), .core_so_oe(core_so_oe),
    .sck_rise_stb(sck_rise_stb), .sck_fall_stb(sck_fall_stb),
    .si_bit(si_bit), .so_oe(so_oe), .paused(paused)
  );

  always @(posedge clk) begin
    if (sck_rise_stb) begin
      rise_cnt <= rise_cnt + 1;
      shreg    <= {shreg[6:0], si_bit};
    end
    if (sck_fall_stb) fall_cnt <= fall_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    si = b;
    wclk(HALF);
    sck = 1'b1;
    wclk(HALF);
    sck = 1'b0;
  endtask

  task automatic select();
    cs_n = 1'b0;
    wclk(6);
  endtask

  task automatic deselect();
    wclk(HALF);
    cs_n = 1'b1;
    wclk(6);
  endtask

  task automatic t_reset();
    chk("R1 paused", paused, 0);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 strobes", rise_cnt + fall_cnt, 0);
  endtask

  task automatic t_run_byte();
    int r0 = rise_cnt, f0 = fall_cnt;
    core_so_oe = 1'b1;
    select();
    chk("R10 so_oe on", so_oe, 1);
    core_so_oe = 1'b0;
    wclk(1);
    chk("R10 so_oe follows core", so_oe, 0);
    core_so_oe = 1'b1;
    for (int i = 7; i >= 0; i--) pulse(8'hA5 >> i);
    wclk(HALF);
    chk("R2 rise count", rise_cnt - r0, 8);
    chk("R2 fall count", fall_cnt - f0, 8);
    chk("R2 byte", shreg, 8'hA5);
    deselect();
    chk("R10 so_oe off deselected", so_oe, 0);
  endtask

  task automatic t_hold_low();
    int r0, f0;
    select();
    for (int i = 7; i >= 5; i--) pulse(8'h6C >> i);
    wclk(2);
    hold_n = 1'b0;
    wclk(6);
    chk("R4 paused", paused, 1);
    chk("R6 so_oe", so_oe, 0);
    r0 = rise_cnt; f0 = fall_cnt;
    for (int k = 0; k < 4; k++) pulse(k[0]);
    wclk(HALF);
    chk("R3 rise masked", rise_cnt - r0, 0);
    chk("R3 fall masked", fall_cnt - f0, 0);
    hold_n = 1'b1;
    wclk(6);
    chk("R7 resumed", paused, 0);
    chk("R10 so_oe back", so_oe, 1);
    for (int i = 4; i >= 0; i--) pulse(8'h6C >> i);
    wclk(HALF);
    chk("R3 byte continues", shreg, 8'h6C);
    deselect();
  endtask

  task automatic t_defer_entry();
    int r0, f0;
    select();
    for (int i = 7; i >= 6; i--) pulse(8'h3B >> i);
    si = 1'b1;
    wclk(HALF);
    sck = 1'b1;
    wclk(HALF);
    f0 = fall_cnt;
    hold_n = 1'b0;
    wclk(5);
    chk("R6 so_oe before pause", so_oe, 0);
    chk("R5 not yet paused", paused, 0);
    sck = 1'b0;
    wclk(6);
    chk("R5 paused after fall", paused, 1);
    chk("R5 fall delivered", fall_cnt - f0, 1);
    r0 = rise_cnt;
    pulse(1'b0);
    wclk(HALF);
    chk("R3 rise masked deferred", rise_cnt - r0, 0);
    hold_n = 1'b1;
    wclk(6);
    chk("R7 resumed", paused, 0);
    for (int i = 4; i >= 0; i--) pulse(8'h3B >> i);
    wclk(HALF);
    chk("R5 byte", shreg, 8'h3B);
    deselect();
  endtask

  task automatic t_defer_exit();
    int r0, f0;
    select();
    for (int i = 7; i >= 4; i--) pulse(8'hD2 >> i);
    wclk(2);
    hold_n = 1'b0;
    wclk(6);
    chk("R4 paused", paused, 1);
    r0 = rise_cnt; f0 = fall_cnt;
    sck = 1'b1;
    wclk(HALF);
    hold_n = 1'b1;
    wclk(6);
    chk("R7 still paused with sck high", paused, 1);
    chk("R6 so_oe held off", so_oe, 0);
    sck = 1'b0;
    wclk(6);
    chk("R7 resumed with sck low", paused, 0);
    chk("R7 fall swallowed", fall_cnt - f0, 0);
    chk("R7 rise swallowed", rise_cnt - r0, 0);
    for (int i = 3; i >= 0; i--) pulse(8'hD2 >> i);
    wclk(HALF);
    chk("R7 byte", shreg, 8'hD2);
    deselect();
  endtask

  task automatic t_cs_clear();
    select();
    pulse(1'b1);
    wclk(2);
    hold_n = 1'b0;
    wclk(6);
    chk("R4 paused", paused, 1);
    cs_n = 1'b1;
    wclk(6);
    chk("R8 cleared", paused, 0);
    hold_n = 1'b1;
    wclk(4);
  endtask

  task automatic t_disabled();
    int r0;
    hold_dis = 1'b1;
    select();
    r0 = rise_cnt;
    for (int i = 7; i >= 4; i--) pulse(8'h97 >> i);
    wclk(2);
    hold_n = 1'b0;
    wclk(6);
    chk("R9 not paused", paused, 0);
    chk("R9 so_oe kept", so_oe, 1);
    for (int i = 3; i >= 0; i--) pulse(8'h97 >> i);
    wclk(HALF);
    chk("R9 rise count", rise_cnt - r0, 8);
    chk("R9 byte", shreg, 8'h97);
    hold_n = 1'b1;
    deselect();
    hold_dis = 1'b0;
  endtask

  initial begin
    wclk(4);
    t_reset();
    rst_n = 1'b1;
    wclk(4);
    t_reset();
    t_run_byte();
    t_hold_low();
    t_defer_entry();
    t_defer_exit();
    t_cs_clear();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule